// File: doc/BRIEF.md
# Burst-Mode Switching Load Generator

This block is a deliberate digital power load. It holds a wide bank of flip-flops. During an active burst, every flip-flop in the bank inverts on every clock. During the idle burst that follows, the bank does not change. The two bursts always have the same length, X clock cycles, and they alternate for as long as the block is enabled. The clock never changes rate. Only X sets the low-frequency envelope of the supply current, which therefore steps between a high level and almost nothing.

X sweeps by itself. It starts at a start length and is held for a programmable number of full active/idle periods. It then grows by a step. When the next value would pass the stop length, X returns to the start length and a one-cycle completion pulse is raised. Dropping the enable freezes everything in place. The bank is folded into one registered parity bit, so synthesis has to keep every toggling register.

Top module: `burst_load_gen`

## Requirements
- R1: While activePhase is high, every bit of the load bank inverts at the next clock edge. With an odd LOAD_W, this makes loadParity flip.
- R2: While activePhase is low, no bit of the load bank changes.
- R3: After reset, the enabled block begins in the active phase. The active and idle phases then alternate, and each lasts exactly curLen enabled cycles.
- R4: After repeatCount complete active+idle periods at one length, curLen becomes curLen+stepLen at the end of the last idle cycle. A repeatCount of 0 acts as 1.
- R5: When curLen+stepLen, computed one bit wider than curLen so it cannot overflow, is greater than stopLen, curLen goes back to the start length instead. sweepDone is high for exactly that one cycle, which is the first cycle that shows the restored length.
- R6: While enable is low, activePhase is low, the bank and loadParity history are frozen, and the phase, period and length counters hold. When enable returns, the sequence resumes where it stopped.
- R7: While rst is high, at each clock edge the block loads curLen with the start length, enters the active phase, clears sweepDone and loadParity, and sets bank bit i to i mod 2.
- R8: loadParity equals the XOR of all bank bits as they stood one clock earlier.
- R9: A startLen of 0 is treated as 1, for both the reset load and the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the burst sequence when high; freezes it when low |
| startLen | input | HALF_W | First half-period length of the sweep |
| stopLen | input | HALF_W | Largest half-period length allowed in the sweep |
| stepLen | input | HALF_W | Amount added to the length at each advance |
| repeatCount | input | REP_W | Full periods spent at each length (0 acts as 1) |
| curLen | output | HALF_W | Half-period length in use |
| activePhase | output | 1 | High during enabled active-phase cycles |
| sweepDone | output | 1 | One-cycle pulse when the sweep wraps to the start length |
| loadParity | output | 1 | Registered XOR of the load bank |

## Verification
The critical coincidence is an enable drop on the final idle cycle of the final repeat at a given length. On that cycle, the phase end, the length advance and possibly the wrap pulse would all happen together. The bench steers enable low on exactly that cycle, using the state of its own behavioural model, and expects no advance, no pulse and an unchanged bank. When enable returns, it expects the deferred advance to follow one cycle later. A second overlap is tested with a length near the top of its range: a length whose advance would overflow must wrap, and the pulse must arrive in the same cycle that the restored length appears.

// File: rtl/burst_load_pkg.sv
package burst_load_pkg;

  // Strobes from the sequencer to the load datapath
  typedef struct packed {
    logic toggleAll;   // invert every bank bit at this edge
  } bankCtl_t;

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_load_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [HALF_W-1:0] startLen,
  input  logic [HALF_W-1:0] stopLen,
  input  logic [HALF_W-1:0] stepLen,
  input  logic [REP_W-1:0]  repeatCount,
  output logic [HALF_W-1:0] curLen,
  output logic              activePhase,
  output logic              sweepDone,
  output bankCtl_t          bankCtl
);

  localparam int EXT_W = HALF_W + 1;

  logic [HALF_W-1:0] lenQ;
  logic [HALF_W-1:0] phaseCntQ;
  logic [REP_W-1:0]  periodQ;
  logic              phaseActQ;
  logic              doneQ;

  logic [HALF_W-1:0] startEff;
  logic [REP_W-1:0]  repEff;
  logic [EXT_W-1:0]  nextLenExt;
  logic              phaseEnd;
  logic              lastRep;
  logic              wrapNow;

  always_comb begin
    startEff   = (startLen == '0) ? HALF_W'(1) : startLen;
    repEff     = (repeatCount == '0) ? REP_W'(1) : repeatCount;
    nextLenExt = {1'b0, lenQ} + {1'b0, stepLen};
    wrapNow    = nextLenExt > {1'b0, stopLen};
    lastRep    = periodQ >= (repEff - REP_W'(1));
    phaseEnd   = enable && (phaseCntQ >= (lenQ - HALF_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenQ      <= startEff;
      phaseCntQ <= '0;
      periodQ   <= '0;
      phaseActQ <= 1'b1;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (phaseEnd) begin
        phaseCntQ <= '0;
        phaseActQ <= ~phaseActQ;
        if (!phaseActQ) begin
          if (lastRep) begin
            periodQ <= '0;
            if (wrapNow) begin
              lenQ  <= startEff;
              doneQ <= 1'b1;
            end else begin
              lenQ <= nextLenExt[HALF_W-1:0];
            end
          end else begin
            periodQ <= periodQ + REP_W'(1);
          end
        end
      end else if (enable) begin
        phaseCntQ <= phaseCntQ + HALF_W'(1);
      end
    end
  end

  assign curLen            = lenQ;
  assign activePhase       = enable & phaseActQ;
  assign sweepDone         = doneQ;
  assign bankCtl.toggleAll = enable & phaseActQ;

endmodule

// File: rtl/burst_load_bank.sv
module burst_load_bank
  import burst_load_pkg::*;
#(
  parameter int LOAD_W = 1024
) (
  input  logic     clk,
  input  logic     rst,
  input  bankCtl_t bankCtl,
  output logic     loadParity
);

  logic [LOAD_W-1:0] bankQ;
  logic              parityQ;

  for (genvar i = 0; i < LOAD_W; i++) begin : g_cell
    localparam logic RST_VAL = (i % 2) == 1;
    always_ff @(posedge clk) begin
      if (rst)                    bankQ[i] <= RST_VAL;
      else if (bankCtl.toggleAll) bankQ[i] <= ~bankQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) parityQ <= 1'b0;
    else     parityQ <= ^bankQ;
  end

  assign loadParity = parityQ;

endmodule

// File: rtl/burst_load_gen.sv
module burst_load_gen
  import burst_load_pkg::*;
#(
  parameter int LOAD_W = 1024,
  parameter int HALF_W = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [HALF_W-1:0] startLen,
  input  logic [HALF_W-1:0] stopLen,
  input  logic [HALF_W-1:0] stepLen,
  input  logic [REP_W-1:0]  repeatCount,
  output logic [HALF_W-1:0] curLen,
  output logic              activePhase,
  output logic              sweepDone,
  output logic              loadParity
);

  bankCtl_t bankCtl;

  burst_load_ctrl #(.HALF_W(HALF_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable),
    .startLen(startLen), .stopLen(stopLen), .stepLen(stepLen),
    .repeatCount(repeatCount),
    .curLen(curLen), .activePhase(activePhase), .sweepDone(sweepDone),
    .bankCtl(bankCtl)
  );

  burst_load_bank #(.LOAD_W(LOAD_W)) u_bank (
    .clk(clk), .rst(rst), .bankCtl(bankCtl), .loadParity(loadParity)
  );

endmodule

// File: rtl/burst_load_chk.sv
module burst_load_chk #(
  parameter int LOAD_W = 1024,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [HALF_W-1:0] startLen,
  input logic [HALF_W-1:0] stepLen,
  input logic [HALF_W-1:0] curLen,
  input logic              activePhase,
  input logic              sweepDone,
  input logic              loadParity
);

  logic [1:0] sinceRst;
  logic       prevAct1, prevAct2, prevPar1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      prevAct1 <= 1'b0;
      prevAct2 <= 1'b0;
      prevPar1 <= 1'b0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      prevAct1 <= activePhase;
      prevAct2 <= prevAct1;
      prevPar1 <= loadParity;
    end
  end

  // R6: disabled means no active phase and the length holds
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !activePhase);
  a_r6_len_held: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !enable) |=> $stable(curLen));

  // R5: the wrap pulse lasts one cycle and shows the start length
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    sweepDone |=> !sweepDone);
  a_r5_done_restart: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && sweepDone) |->
      curLen == (($past(startLen) == '0) ? HALF_W'(1) : $past(startLen)));

  // R4: any change in length is a step or a wrap
  a_r4_len_step: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && curLen != $past(curLen)) |->
      (sweepDone || ({1'b0, curLen} == {1'b0, $past(curLen)} + {1'b0, $past(stepLen)})));

  // R9: the length never reads zero
  a_r9_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    curLen != '0);

  // R2: an idle cycle leaves the bank, and so the parity, unchanged
  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && !prevAct2) |-> loadParity == prevPar1);

  // R1: with an odd width, an active cycle flips the parity
  if (LOAD_W % 2 == 1) begin : g_odd
    a_r1_active_flip: assert property (@(posedge clk) disable iff (rst)
      (sinceRst >= 2'd2 && prevAct2) |-> loadParity != prevPar1);
  end

endmodule

bind burst_load_gen burst_load_chk #(.LOAD_W(LOAD_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .startLen(startLen),
  .stepLen(stepLen), .curLen(curLen), .activePhase(activePhase),
  .sweepDone(sweepDone), .loadParity(loadParity)
);

// File: tb/tb_burst_load_gen.sv
module tb_burst_load_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 33;
  localparam int HW = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [HW-1:0] startLen = 8'd2, stopLen = 8'd5, stepLen = 8'd1;
  logic [RW-1:0] repeatCount = 4'd1;
  logic [HW-1:0] curLen;
  logic          activePhase, sweepDone, loadParity;

  burst_load_gen #(.LOAD_W(LW), .HALF_W(HW), .REP_W(RW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .startLen(startLen),
    .stopLen(stopLen), .stepLen(stepLen), .repeatCount(repeatCount),
    .curLen(curLen), .activePhase(activePhase), .sweepDone(sweepDone),
    .loadParity(loadParity)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit modelValid = 0, finished = 0;

  // behavioural reference state
  int mLen, mCnt, mPer, mAct, mDone, mBankPar, mParQ;

  function automatic int startEffF();
    return (startLen == 0) ? 1 : int'(startLen);
  endfunction
  function automatic int repEffF();
    return (repeatCount == 0) ? 1 : int'(repeatCount);
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mLen = startEffF(); mCnt = 0; mPer = 0; mAct = 1; mDone = 0;
      mBankPar = (LW / 2) % 2; mParQ = 0;
      modelValid = 1;
    end else begin
      int act;
      act   = (enable && mAct) ? 1 : 0;
      mParQ = mBankPar;
      if (act == 1) mBankPar = mBankPar ^ (LW % 2);
      mDone = 0;
      if (enable) begin
        if (mCnt == mLen - 1) begin
          mCnt = 0;
          if (mAct == 0) begin
            if (mPer == repEffF() - 1) begin
              mPer = 0;
              if (mLen + int'(stepLen) > int'(stopLen)) begin
                mLen = startEffF(); mDone = 1;
              end else mLen = mLen + int'(stepLen);
            end else mPer++;
          end
          mAct = 1 - mAct;
        end else mCnt++;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (modelValid && !finished) begin
      check("R4/R5/R7/R9 curLen", int'(curLen), mLen);
      check("R3/R6 activePhase", int'(activePhase), (enable && mAct) ? 1 : 0);
      check("R5 sweepDone", int'(sweepDone), mDone);
      check("R1/R2/R8 loadParity", int'(loadParity), mParQ);
    end
  end

  task automatic do_reset(int s, int e, int st, int rp);
    @(posedge clk); #1;
    rst = 1; enable = 1;
    startLen = HW'(s); stopLen = HW'(e); stepLen = HW'(st); repeatCount = RW'(rp);
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state seen at the ports
    check("R7 reset curLen", int'(curLen), (s == 0) ? 1 : s);
    check("R7 reset sweepDone", int'(sweepDone), 0);
    check("R7 reset loadParity", int'(loadParity), 0);
    rst = 0;
  endtask

  task automatic run(int n, int offEvery);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      enable = (offEvery > 0 && (k % offEvery) == offEvery - 1) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    // R3/R4/R5: plain sweep 2..5 step 1
    do_reset(2, 5, 1, 1);
    run(80, 0);
    // R6/R4: enable gaps, two repeats, overshooting step
    do_reset(1, 6, 3, 2);
    run(150, 7);
    // R9: zero start behaves as one
    do_reset(0, 2, 1, 1);
    run(40, 0);
    // R5: start above stop wraps every period
    do_reset(5, 3, 1, 1);
    run(40, 0);
    // R5: advance would overflow the length width
    do_reset(250, 255, 10, 1);
    run(1100, 0);
    // R6 with R4/R5: drop enable exactly on the final idle cycle
    do_reset(3, 4, 1, 1);
    for (int k = 0; k < 120; k++) begin
      @(posedge clk); #1;
      if (!enable) enable = 1;
      else if (mAct == 0 && mCnt == mLen - 1 && mPer == repEffF() - 1 && (k % 3) != 2)
        enable = 0;
    end
    // R6: long freeze mid-burst
    do_reset(6, 6, 0, 1);
    run(5, 0);
    enable = 0;
    repeat (20) @(posedge clk);
    #1;
    run(30, 0);
    @(negedge clk);
    summary();
  end

endmodule